// File: doc/BRIEF.md
# File-Register Increment/Decrement Execute Unit

This block is the execute stage of a small 8-bit accumulator machine. On each cycle in which its valid strobe is high it carries out one operation. It can add one to a file register, subtract one from a file register, do either of those without touching the zero flag, or OR an immediate byte into the working register (W). The block holds a 32-entry by 8-bit register file, the W register and a zero flag.

Increment and decrement send their result either to W or back to the addressed file register, as the destination bit selects. Every operation also leaves a registered copy of its 8-bit result and a "result was zero" bit. The sequencer uses that bit for its skip decision. Program counter handling, fetch and the skip itself sit outside this block.

Top module: `regfile_incdec_exec`

## Requirements
- R1: `fileAddr` selects one of 32 independent 8-bit file registers (0 to 31), and an operation on one address never alters any other address.
- R2: For an increment or decrement with `destFile` = 0, the new value is written to W and the addressed file register keeps its value.
- R3: For an increment or decrement with `destFile` = 1, the new value is written to the addressed file register and W keeps its value.
- R4: Plain increment (opCode 0) and plain decrement (opCode 1) set `zFlag` to 1 when the 8-bit result is 0x00, and clear it otherwise.
- R5: Increment-skip (opCode 2) and decrement-skip (opCode 3) produce the same value and destination as opCodes 0 and 1, and leave `zFlag` unchanged.
- R6: OR-literal (opCode 4) writes W | `literal` to W, updates `zFlag` from that value, and leaves every file register alone whatever `fileAddr` and `destFile` hold.
- R7: Arithmetic wraps modulo 256: 0xFF incremented gives 0x00, and 0x00 decremented gives 0xFF.
- R8: After any executed operation, `result` holds its 8-bit value and `resultZero` is 1 exactly when that value is 0x00, starting at the following clock edge. This holds for skip variants too.
- R9: A synchronous reset (`rst` high at a clock edge) clears W, `zFlag`, `result`, `resultZero` and all 32 file registers.
- R10: While `opValid` is low, no register, flag or output changes.
- R11: opCodes 5, 6 and 7 are not operations. With `opValid` high they change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Execute the presented operation this cycle |
| opCode | input | 3 | 0 inc, 1 dec, 2 inc-skip, 3 dec-skip, 4 OR-literal |
| fileAddr | input | 5 | File register address |
| destFile | input | 1 | 1 writes the file register, 0 writes W |
| literal | input | 8 | Immediate for OR-literal |
| result | output | 8 | Registered value of the last operation |
| resultZero | output | 1 | Registered: last value was zero |
| wReg | output | 8 | Working register |
| zFlag | output | 1 | Zero flag |

## Verification
The bench goes after the wrap points. It decrements to zero, then below zero, then increments back past 0xFF. A design that kept a ninth bit or saturated would show 0x100 truncation errors or would stick at the limit. Skip variants are run when the zero flag disagrees with the new result, so a design that let them write the flag would show a wrong `zFlag`, and one that gated `resultZero` on the flag write would miss the skip. Both destination settings are read back through later increments into W, which exposes a design that writes both places. Idle cycles, unused opCodes and a reset in the middle of the run are checked the same way, and a stray write or a file register that reset failed to clear shows up in later results.

// File: rtl/incdec_pkg.sv
package incdec_pkg;

  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 32;
  localparam int OP_W     = 3;

  // Operation encodings seen on opCode
  localparam logic [OP_W-1:0] OPC_INC     = 3'd0;
  localparam logic [OP_W-1:0] OPC_DEC     = 3'd1;
  localparam logic [OP_W-1:0] OPC_INC_SKP = 3'd2;
  localparam logic [OP_W-1:0] OPC_DEC_SKP = 3'd3;
  localparam logic [OP_W-1:0] OPC_OR_LIT  = 3'd4;

  typedef enum logic [1:0] {
    ALU_INC = 2'd0,
    ALU_DEC = 2'd1,
    ALU_OR  = 2'd2
  } aluSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    latch;   // capture result / resultZero
    logic    wrW;     // write W
    logic    wrFile;  // write addressed file register
    logic    updZ;    // write zero flag
    aluSel_t aluSel;  // arithmetic selection
  } strobes_t;

endpackage

// File: rtl/incdec_ctrl.sv
module incdec_ctrl
  import incdec_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic           opValid,
  input  logic [OPW-1:0] opCode,
  input  logic           destFile,
  output strobes_t       strb
);

  always_comb begin
    strb = '{latch: 1'b0, wrW: 1'b0, wrFile: 1'b0, updZ: 1'b0, aluSel: ALU_INC};
    if (opValid) begin
      unique case (opCode)
        OPC_INC, OPC_DEC, OPC_INC_SKP, OPC_DEC_SKP: begin
          strb.latch  = 1'b1;
          strb.wrW    = !destFile;
          strb.wrFile = destFile;
          strb.updZ   = (opCode == OPC_INC) || (opCode == OPC_DEC);
          strb.aluSel = ((opCode == OPC_DEC) || (opCode == OPC_DEC_SKP)) ? ALU_DEC : ALU_INC;
        end
        OPC_OR_LIT: begin
          strb.latch  = 1'b1;
          strb.wrW    = 1'b1;
          strb.updZ   = 1'b1;
          strb.aluSel = ALU_OR;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/incdec_alu.sv
module incdec_alu
  import incdec_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  aluSel_t       aluSel,
  input  logic [DW-1:0] fileVal,
  input  logic [DW-1:0] wVal,
  input  logic [DW-1:0] litVal,
  output logic [DW-1:0] aluOut,
  output logic          aluZero
);

  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    unique case (aluSel)
      ALU_INC: aluOut = fileVal + ONE;
      ALU_DEC: aluOut = fileVal - ONE;
      ALU_OR:  aluOut = wVal | litVal;
      default: aluOut = '0;
    endcase
    aluZero = (aluOut == '0);
  end

endmodule

// File: rtl/incdec_dpath.sv
module incdec_dpath
  import incdec_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NREGS = NUM_REGS,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  strobes_t      strb,
  input  logic [AW-1:0] fileAddr,
  input  logic [DW-1:0] literal,
  output logic [DW-1:0] result,
  output logic          resultZero,
  output logic [DW-1:0] wReg,
  output logic          zFlag
);

  logic [DW-1:0] fileMem [NREGS];
  logic [DW-1:0] fileRd;
  logic [DW-1:0] aluOut;
  logic          aluZero;

  assign fileRd = fileMem[fileAddr];

  incdec_alu #(.DW(DW)) u_alu (
    .aluSel  (strb.aluSel),
    .fileVal (fileRd),
    .wVal    (wReg),
    .litVal  (literal),
    .aluOut  (aluOut),
    .aluZero (aluZero)
  );

  // File register array, one write port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) fileMem[i] <= '0;
    end else if (strb.wrFile) begin
      fileMem[fileAddr] <= aluOut;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wReg       <= '0;
      zFlag      <= 1'b0;
      result     <= '0;
      resultZero <= 1'b0;
    end else begin
      if (strb.wrW)   wReg  <= aluOut;
      if (strb.updZ)  zFlag <= aluZero;
      if (strb.latch) begin
        result     <= aluOut;
        resultZero <= aluZero;
      end
    end
  end

endmodule

// File: rtl/regfile_incdec_exec.sv
module regfile_incdec_exec
  import incdec_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NREGS = NUM_REGS,
  parameter int OPW   = OP_W,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          opValid,
  input  logic [OPW-1:0] opCode,
  input  logic [AW-1:0] fileAddr,
  input  logic          destFile,
  input  logic [DW-1:0] literal,
  output logic [DW-1:0] result,
  output logic          resultZero,
  output logic [DW-1:0] wReg,
  output logic          zFlag
);

  strobes_t strb;

  incdec_ctrl #(.OPW(OPW)) u_ctrl (
    .opValid  (opValid),
    .opCode   (opCode),
    .destFile (destFile),
    .strb     (strb)
  );

  incdec_dpath #(.DW(DW), .NREGS(NREGS)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .fileAddr   (fileAddr),
    .literal    (literal),
    .result     (result),
    .resultZero (resultZero),
    .wReg       (wReg),
    .zFlag      (zFlag)
  );

endmodule

// File: rtl/incdec_exec_chk.sv
module incdec_exec_chk
  import incdec_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int OPW = OP_W
) (
  input logic           clk,
  input logic           rst,
  input logic           opValid,
  input logic [OPW-1:0] opCode,
  input logic           destFile,
  input logic [DW-1:0]  result,
  input logic           resultZero,
  input logic [DW-1:0]  wReg,
  input logic           zFlag
);

  logic isArith;
  logic isSkip;
  logic isPlain;
  logic isKnown;

  assign isArith = opValid && (opCode <= OPC_DEC_SKP);
  assign isSkip  = opValid && ((opCode == OPC_INC_SKP) || (opCode == OPC_DEC_SKP));
  assign isPlain = opValid && ((opCode == OPC_INC) || (opCode == OPC_DEC));
  assign isKnown = opValid && (opCode <= OPC_OR_LIT);

  // R2: value routed to W appears as the result
  p_dest_w_r2: assert property (@(posedge clk) disable iff (rst)
    (isArith && !destFile) |=> (wReg == result));

  // R3: file destination leaves W alone
  p_dest_file_r3: assert property (@(posedge clk) disable iff (rst)
    (isArith && destFile) |=> $stable(wReg));

  // R4: plain ops copy zero status into the flag
  p_plain_z_r4: assert property (@(posedge clk) disable iff (rst)
    isPlain |=> (zFlag == resultZero));

  // R5: skip variants keep the flag
  p_skip_keeps_z_r5: assert property (@(posedge clk) disable iff (rst)
    isSkip |=> $stable(zFlag));

  // R6: OR literal lands in W and the flag
  p_or_lit_r6: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OPC_OR_LIT) |=> ((wReg == result) && (zFlag == resultZero)));

  // R8: zero indication agrees with the result
  p_result_zero_r8: assert property (@(posedge clk) disable iff (rst)
    isKnown |=> (resultZero == (result == '0)));

  // R9: reset clears observable state
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> ((wReg == '0) && !zFlag && (result == '0) && !resultZero));

  // R10 and R11: nothing moves without a known, valid operation
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !isKnown |=> ($stable(wReg) && $stable(zFlag) && $stable(result) && $stable(resultZero)));

endmodule

bind regfile_incdec_exec incdec_exec_chk #(.DW(DW), .OPW(OPW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opValid    (opValid),
  .opCode     (opCode),
  .destFile   (destFile),
  .result     (result),
  .resultZero (resultZero),
  .wReg       (wReg),
  .zFlag      (zFlag)
);

// File: tb/regfile_incdec_exec_tb.sv
module regfile_incdec_exec_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk;
  logic       rst;
  logic       opValid;
  logic [2:0] opCode;
  logic [4:0] fileAddr;
  logic       destFile;
  logic [7:0] literal;
  logic [7:0] result;
  logic       resultZero;
  logic [7:0] wReg;
  logic       zFlag;

  int testsRun = 0;
  int testsFailed = 0;

  // Behavioural reference state
  int  refMem [32];
  int  refW, refRes;
  bit  refZ, refResZ;

  regfile_incdec_exec u_dut (
    .clk        (clk),
    .rst        (rst),
    .opValid    (opValid),
    .opCode     (opCode),
    .fileAddr   (fileAddr),
    .destFile   (destFile),
    .literal    (literal),
    .result     (result),
    .resultZero (resultZero),
    .wReg       (wReg),
    .zFlag      (zFlag)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic void refReset();
    for (int i = 0; i < 32; i++) refMem[i] = 0;
    refW = 0; refZ = 0; refRes = 0; refResZ = 0;
  endfunction

  function automatic void refApply(bit v, int op, int a, bit d, int lit);
    int r;
    if (!v || op > 4) return;
    if (op == 4) begin
      r = refW | lit;
      refW = r;
      refZ = (r == 0);
    end else begin
      if (op == 0 || op == 2) r = (refMem[a] + 1) % 256;
      else                    r = (refMem[a] + 255) % 256;
      if (d) refMem[a] = r; else refW = r;
      if (op < 2) refZ = (r == 0);
    end
    refRes = r;
    refResZ = (r == 0);
  endfunction

  task automatic checkOne(string tag, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    checkOne(tag, "result", int'(result), refRes);
    checkOne(tag, "resultZero", int'(resultZero), int'(refResZ));
    checkOne(tag, "wReg", int'(wReg), refW);
    checkOne(tag, "zFlag", int'(zFlag), int'(refZ));
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(bit v, int op, int a, bit d, int lit, string tag);
    opValid  = v;
    opCode   = 3'(op);
    fileAddr = 5'(a);
    destFile = d;
    literal  = 8'(lit);
    refApply(v, op, a, d, lit);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic doReset(string tag);
    rst = 1'b1;
    opValid = 1'b1; opCode = 3'd0; fileAddr = 5'd3; destFile = 1'b1; literal = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    opValid = 1'b0;
    refReset();
    compareAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rst = 1'b1;
    opValid = 1'b0; opCode = '0; fileAddr = '0; destFile = 1'b0; literal = '0;
    refReset();
    @(negedge clk);
    doReset("R9");

    // R6: OR of zero into cleared W sets Z; nonzero clears it; file ignored
    step(1, 4, 9, 1, 8'h00, "R6");
    step(1, 4, 9, 1, 8'h5A, "R6");
    step(1, 0, 9, 0, 0, "R6");          // file 9 still zero -> W = 1

    // R1 / R3: give every address its own value
    for (int a = 0; a < 32; a++) begin
      step(1, 0, a, 1, 0, "R3");
      if (a % 2 == 0) step(1, 0, a, 1, 0, "R3");
      if (a % 3 == 0) step(1, 1, a, 1, 0, "R3");
    end
    for (int a = 0; a < 32; a++) step(1, 0, a, 0, 0, "R1");

    // R2: destination W leaves file intact
    step(1, 1, 5, 0, 0, "R2");
    step(1, 1, 5, 0, 0, "R2");
    step(1, 0, 5, 0, 0, "R2");

    // R4 / R7: wrap points on file 7 (holds 1)
    step(1, 1, 7, 1, 0, "R4");          // 0, Z=1
    step(1, 1, 7, 1, 0, "R7");          // 0xFF, Z=0
    step(1, 0, 7, 1, 0, "R7");          // 0x00, Z=1
    step(1, 0, 7, 0, 0, "R4");          // W=1, Z=0

    // R5 / R8: skip variants vs. flag
    step(1, 4, 0, 0, 8'h10, "R6");
    step(1, 3, 7, 1, 0, "R5");          // 0xFF, Z stays 0
    step(1, 2, 7, 1, 0, "R8");          // 0x00, resultZero=1, Z stays 0
    step(1, 1, 7, 1, 0, "R4");          // 0xFF, Z=0
    step(1, 0, 7, 1, 0, "R4");          // 0, Z=1
    step(1, 2, 7, 1, 0, "R5");          // 1, Z stays 1, resultZero 0
    step(1, 3, 7, 0, 0, "R5");          // W=0, Z stays 1

    // R10: idle cycles with live-looking inputs
    step(0, 0, 7, 1, 0, "R10");
    step(0, 4, 7, 0, 8'hFF, "R10");
    step(1, 0, 7, 0, 0, "R10");         // reveals file 7 unchanged

    // R11: unused codes
    for (int op = 5; op < 8; op++) step(1, op, 7, 1, 8'hFF, "R11");
    step(1, 0, 7, 0, 0, "R11");

    // R9: reset mid-run clears file registers
    doReset("R9");
    step(1, 0, 7, 0, 0, "R9");
    step(1, 1, 20, 0, 0, "R9");

    // R1: mixed traffic
    for (int i = 0; i < 600; i++)
      step(($urandom % 4) != 0, $urandom % 8, $urandom % 32, $urandom % 2, $urandom % 256, "R1");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule